// File: doc/BRIEF.md
# Conditional Jump Decision Unit

This block decides whether a conditional jump is taken. It takes a 5-bit condition field and the processor's three status flags: zero (Z), carry (C) and negative (N). The flags arrive in the same packed 3-bit layout that the flags register uses. The condition is not an enumerated list of named cases. Each of its low four bits switches on an independent test, and the jump is taken only when every enabled test passes. The top bit chooses which flag the second pair of tests looks at.

Instruction decode and program-counter update sit outside the block. A decode stage presents a condition and the current flags together with a valid strobe. The unit returns a taken/not-taken bit with its own valid strobe. By default the answer is registered and arrives exactly one cycle later. A parameter removes that register for a purely combinational path.

Top module: `jump_cond_unit`

## Requirements
- R1: With condition bit 0 set, the jump is not taken while Z is 1.
- R2: With condition bit 1 set, the jump is not taken while Z is 0.
- R3: With condition bit 2 set, the jump is not taken while the selected flag is 1.
- R4: With condition bit 3 set, the jump is not taken while the selected flag is 0.
- R5: Condition bit 4 picks the flag used by bits 2 and 3: 0 picks carry, 1 picks negative.
- R6: A condition of all zeros is always taken, whatever the flags are.
- R7: The flag input is packed as Z in bit 0, C in bit 1 and N in bit 2.
- R8: A condition with bits 0 and 1 both set, or bits 2 and 3 both set, is never taken. No special decoding is needed for this.
- R9: In registered mode (the default), the decision for a request presented with valid_i high appears on take_o, with valid_o high, exactly one clock later. valid_o is low the cycle after valid_i is low. take_o is 0 whenever valid_o is 0.
- R10: While reset is high, and on the first cycle after it, valid_o and take_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe for cond_i and flags_i |
| cond_i | input | 5 | Condition field |
| flags_i | input | 3 | Packed flags: bit 0 Z, bit 1 C, bit 2 N |
| valid_o | output | 1 | Decision strobe |
| take_o | output | 1 | 1 when the jump is taken |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe relation;
- the quiet take_o when no result is valid;
- the always-taken all-zero condition;
- the never-taken contradictory conditions;
- the zero-flag tests against the packed flag bits.

Only the bench's scenarios can show that the carry/negative selection routes the right flag bit. The bench drives an exhaustive sweep of all 256 condition and flag combinations, with gaps in the strobe. It compares each result against an independently written model.

// File: rtl/jcu_pkg.sv
package jcu_pkg;
  localparam int COND_W   = 5;
  localparam int FLAG_W   = 3;
  localparam int NUM_TEST = 4;

  // Packed flag layout: bit2 negative, bit1 carry, bit0 zero
  typedef struct packed {
    logic neg;
    logic carry;
    logic zero;
  } flags_t;

  // Condition layout: bit4 flag choice, bit3/2 selected flag one/zero, bit1/0 zero flag one/zero
  typedef struct packed {
    logic use_neg;
    logic sel_one;
    logic sel_zero;
    logic z_one;
    logic z_zero;
  } cond_t;
endpackage

// File: rtl/jcu_flag_pick.sv
module jcu_flag_pick
  import jcu_pkg::*;
(
  input  flags_t flags,
  input  logic   use_neg,
  output logic   z_flag,
  output logic   sel_flag
);
  always_comb begin
    z_flag   = flags.zero;
    sel_flag = use_neg ? flags.neg : flags.carry;
  end
endmodule

// File: rtl/jcu_test_bank.sv
module jcu_test_bank
  import jcu_pkg::*;
#(
  parameter int TESTS = NUM_TEST
) (
  input  logic [TESTS-1:0] enable,
  input  logic [TESTS-1:0] want,
  input  logic [TESTS-1:0] seen,
  output logic             pass
);
  logic [TESTS-1:0] fail;

  genvar gi;
  generate
    for (gi = 0; gi < TESTS; gi++) begin : g_test
      assign fail[gi] = enable[gi] & (seen[gi] ^ want[gi]);
    end
  endgenerate

  assign pass = ~|fail;
endmodule

// File: rtl/jcu_out_stage.sv
module jcu_out_stage #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic take_i,
  output logic valid_o,
  output logic take_o
);
  generate
    if (REGISTERED) begin : g_reg
      logic v_q, t_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          t_q <= 1'b0;
        end else begin
          v_q <= valid_i;
          t_q <= valid_i & take_i;
        end
      end
      assign valid_o = v_q;
      assign take_o  = t_q;

      // R9
      strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
      // R9
      strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
      // R9
      quiet_take_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> !take_o);
      // R9
      take_carry_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (take_o == $past(take_i)));
    end else begin : g_comb
      assign valid_o = valid_i;
      assign take_o  = valid_i & take_i;
    end
  endgenerate
endmodule

// File: rtl/jump_cond_unit.sv
module jump_cond_unit
  import jcu_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic              take_o
);
  cond_t  cond;
  flags_t flags;
  logic   z_flag, sel_flag, pass;
  logic [NUM_TEST-1:0] en, want, seen;

  assign cond  = cond_t'(cond_i);
  assign flags = flags_t'(flags_i);

  jcu_flag_pick u_pick (
    .flags    (flags),
    .use_neg  (cond.use_neg),
    .z_flag   (z_flag),
    .sel_flag (sel_flag)
  );

  // test order: zero-clear, zero-set, selected-clear, selected-set
  assign en   = {cond.sel_one, cond.sel_zero, cond.z_one, cond.z_zero};
  assign want = 4'b1010;
  assign seen = {sel_flag, sel_flag, z_flag, z_flag};

  jcu_test_bank #(.TESTS(NUM_TEST)) u_bank (
    .enable (en),
    .want   (want),
    .seen   (seen),
    .pass   (pass)
  );

  jcu_out_stage #(.REGISTERED(REGISTERED)) u_out (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .take_i  (pass),
    .valid_o (valid_o),
    .take_o  (take_o)
  );

  generate
    if (REGISTERED) begin : g_chk
      // R6
      zero_cond_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i == '0) |=> take_o);
      // R8
      z_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i[1:0] == 2'b11) |=> !take_o);
      // R8
      sel_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i[3:2] == 2'b11) |=> !take_o);
      // R1
      z_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i[0] && flags_i[0]) |=> !take_o);
      // R2
      z_set_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i[1] && !flags_i[0]) |=> !take_o);
    end
  endgenerate
endmodule

// File: tb/jump_cond_unit_bench.sv
module jump_cond_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       valid_i = 1'b0;
  logic [4:0] cond_i = '0;
  logic [2:0] flags_i = '0;
  logic       valid_o, take_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;
  bit stim_done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  jump_cond_unit u_jump_cond_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .cond_i(cond_i),
    .flags_i(flags_i), .valid_o(valid_o), .take_o(take_o)
  );

  // Reference model written from R1..R8, flags packed per R7
  function automatic bit model(input logic [4:0] c, input logic [2:0] f);
    bit z, s, ok;
    z  = f[0];
    s  = c[4] ? f[2] : f[1];   // R5
    ok = 1'b1;
    if (c[0] && z)  ok = 1'b0; // R1
    if (c[1] && !z) ok = 1'b0; // R2
    if (c[2] && s)  ok = 1'b0; // R3
    if (c[3] && !s) ok = 1'b0; // R4
    return ok;
  endfunction

  function automatic string pick_tag(input logic [4:0] c);
    if (c == 5'd0) return "R6";
    if (c[1:0] == 2'b11 || c[3:2] == 2'b11) return "R8";
    if (c[4] && c[3:2] != 2'b00) return "R5";
    if (c[3]) return "R4";
    if (c[2]) return "R3";
    if (c[1]) return "R2";
    if (c[0]) return "R1";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [2:0] f);
    @(negedge clk);
    valid_i = 1'b1;
    cond_i  = c;
    flags_i = f;
    exp_q.push_back(model(c, f));
    tag_q.push_back(pick_tag(c));
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    cond_i  = 5'h1f;
    flags_i = 3'h7;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", 1, 0);
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(take_o == e, t, take_o, e);
        end
      end else begin
        check(take_o == 1'b0, "R9", take_o, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      check(valid_o == 1'b0, "R10", valid_o, 0);
      check(take_o == 1'b0, "R10", take_o, 0);
    end
    valid_i = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    valid_i = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0, "R10", valid_o, 0);
    // Exhaustive sweep: R1..R8, with valid gaps (R9)
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 8; f++) begin
        drive(c[4:0], f[2:0]);
        if (f == 3) idle();
      end
    end
    // Targeted cases: R6 always taken, R5 flag choice, R7 packing
    drive(5'd0, 3'b111);
    drive(5'b00100, 3'b100); // carry clear, negative set: R5 taken
    drive(5'b10100, 3'b100); // negative picked: R5 not taken
    drive(5'b01000, 3'b010); // carry set: R7 taken
    drive(5'b00001, 3'b001); // zero set: R1 not taken
    drive(5'b00011, 3'b000); // R8
    idle();
    // R9: a single strobe gives exactly one result
    idle();
    drive(5'b00010, 3'b001);
    idle();
    @(negedge clk);
    check(valid_o == 1'b0, "R9", valid_o, 0);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    finish_run();
  end
endmodule